// File: doc/BRIEF.md
# Console Transmit Register Interface

This block gives a processor a two-register window onto a byte-wide console output. A write to the data address latches the low byte, clears the ready flag, withdraws any pending interrupt and starts a transfer toward a transmit sink over a valid/ready handshake. The ready flag stays clear until the sink takes the byte. When the sink takes it, ready is set again and an interrupt is raised if interrupts are enabled.

The first offer to the sink comes a programmable number of cycles after the data write. If the sink refuses an offer, the block withdraws the byte, waits the same number of cycles and offers it again. It keeps doing this until the byte is accepted, so no byte is ever dropped. The status address reads back the ready and interrupt-enable bits. Of the status bits, only interrupt enable can be written. Turning the sink's byte into a serial line is left to logic outside this block.

Top module: `console_tx_regs`

## Requirements
- R1: After reset, ready is 1, interrupt enable is 0, irq is 0, tx_valid is 0 and tx_data is 0. A reset during a transfer cancels that transfer.
- R2: A write with bus_sel=1 (the data address) places bus_wdata[7:0] on tx_data, clears ready and clears irq on the next clock edge.
- R3: After a data write with wait_cycles=W, tx_valid first goes high exactly W clock edges after the write edge.
- R4: A clock edge with tx_valid and tx_ready both high ends the transfer. After that edge ready is 1, tx_valid is 0, and irq equals interrupt enable.
- R5: A clock edge with tx_valid high and tx_ready low is a refusal. For W>0, tx_valid drops for W cycles and then offers the same byte again. For W=0, tx_valid stays high. In both cases ready stays 0.
- R6: A read with bus_sel=0 (the status address) returns ready in bit 7 and interrupt enable in bit 6, with all other bits 0. A read with bus_sel=1 returns 0.
- R7: A write with bus_sel=0 sets interrupt enable from bus_wdata[6] and ignores every other bit. Writing 0 clears a pending irq. Writing 1 while ready is 1 raises irq on the next edge.
- R8: tx_ready has no effect while no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| wait_cycles | input | WAIT_W | Cycles before each offer to the sink |
| tx_valid | output | 1 | Byte offered to the sink |
| tx_ready | input | 1 | Sink accepts the offered byte |
| tx_data | output | 8 | Byte being transferred |
| irq | output | 1 | Transmit-ready interrupt request |

## Verification
A wrong wait counter appears at tx_valid. The first offer, or an offer after a refusal, lands on the wrong edge, and the bench sees this within one cycle because it predicts every offer edge arithmetically from W. A stuck busy or ready bit appears at the status register one cycle after the write or the acceptance. A wrongly latched byte or interrupt state appears on tx_data or irq at the edge that follows.

// File: rtl/console_tx_regs.sv
module console_tx_regs #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam int RDY_BIT = 7;
  localparam int IE_BIT  = 6;

  logic              rdy_q, ie_q, irq_q, busy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [7:0]        buf_q;

  wire data_wr = bus_wr & bus_sel;
  wire stat_wr = bus_wr & ~bus_sel;
  wire offer   = busy_q & (cnt_q == '0);
  wire accept  = offer & tx_ready;

  assign tx_valid = offer;
  assign tx_data  = buf_q;
  assign irq      = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (!bus_sel) begin
      bus_rdata[RDY_BIT] = rdy_q;
      bus_rdata[IE_BIT]  = ie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      rdy_q  <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (data_wr) begin
      buf_q  <= bus_wdata;
      rdy_q  <= 1'b0;
      busy_q <= 1'b1;
      cnt_q  <= wait_cycles;
    end else if (busy_q) begin
      if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      else if (tx_ready) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
      end else
        cnt_q <= wait_cycles;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (stat_wr)
        ie_q <= bus_wdata[IE_BIT];
      if (data_wr)
        irq_q <= 1'b0;
      else if (stat_wr)
        irq_q <= bus_wdata[IE_BIT] & (rdy_q | accept);
      else if (accept)
        irq_q <= ie_q;
    end
  end
endmodule

// File: rtl/console_tx_chk.sv
module console_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic [7:0] bus_wdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       irq,
  input logic       rdy,
  input logic       ie
);
  assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_sel |=> !rdy && !irq && tx_data == $past(bus_wdata));

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !bus_wr |=> rdy && !tx_valid && irq == ie);

  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !bus_wr |=> !rdy && $stable(tx_data));

  assert_offer_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rdy);

  assert_ie_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_sel && !bus_wdata[6] |=> !irq && !ie);

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie && rdy);
endmodule

bind console_tx_regs console_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .irq(irq), .rdy(rdy_q), .ie(ie_q)
);

// File: tb/test_console_tx_regs.sv
`timescale 1ns/1ps
module test_console_tx_regs;
  localparam int WAIT_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_sel = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic [WAIT_W-1:0] wait_cycles = '0;
  logic              tx_valid;
  logic              tx_ready = 1'b0;
  logic [7:0]        tx_data;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  console_tx_regs #(.WAIT_W(WAIT_W)) i_console_tx_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_cycles(wait_cycles),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic check_status(string req, int rdy, int ie);
    bus_sel = 1'b0; #1;
    check(req, bus_rdata, (rdy << 7) | (ie << 6));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(int w, int refusals, int ie, logic [7:0] byte_in);
    int offers;
    wait_cycles = WAIT_W'(w);
    write_reg(1'b0, ie ? 8'hFF : 8'hBF);
    check_status("R7", 1, ie);
    check("R7", irq, ie);
    write_reg(1'b1, byte_in);
    check("R2", tx_data, byte_in);
    check("R2", irq, 0);
    offers = 0;
    for (int t = 0; offers <= refusals; t++) begin
      logic ev;
      ev = (t >= w) && ((t - w) % (w + 1) == 0);
      check("R3_R5 valid", tx_valid, ev);
      check_status("R5 ready held", 0, ie);
      check("R5 data held", tx_data, byte_in);
      tx_ready = ev && (offers == refusals);
      if (ev) offers++;
      @(posedge clk); @(negedge clk);
      tx_ready = 1'b0;
    end
    check("R4 valid", tx_valid, 0);
    check_status("R4 ready", 1, ie);
    check("R4 irq", irq, ie);
  endtask

  initial begin
    do_reset();
    check("R1 valid", tx_valid, 0);
    check("R1 data", tx_data, 0);
    check("R1 irq", irq, 0);
    check_status("R1 status", 1, 0);
    bus_sel = 1'b1; #1;
    check("R6 data read", bus_rdata, 0);
    bus_sel = 1'b0;

    tx_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 valid", tx_valid, 0);
    check_status("R8 status", 1, 0);
    check("R8 irq", irq, 0);
    tx_ready = 1'b0;

    write_reg(1'b0, 8'h40);
    check("R7 raise", irq, 1);
    check_status("R6", 1, 1);
    write_reg(1'b0, 8'h00);
    check("R7 clear", irq, 0);
    write_reg(1'b0, 8'hBF);
    check_status("R7 other bits", 1, 0);

    for (int w = 0; w <= 5; w++)
      for (int r = 0; r <= 3; r++)
        for (int ie = 0; ie <= 1; ie++)
          run_case(w, r, ie, 8'((w * 37 + r * 11 + ie * 101) ^ 8'hA5));

    wait_cycles = 8'd3;
    write_reg(1'b0, 8'h40);
    write_reg(1'b1, 8'h5A);
    check("R2 irq drop", irq, 0);
    do_reset();
    check("R1 cancel valid", tx_valid, 0);
    check("R1 cancel data", tx_data, 0);
    check_status("R1 cancel status", 1, 0);
    tx_ready = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R1 cancel no offer", tx_valid, 0);
    end
    tx_ready = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule